// File: doc/BRIEF.md
# Direct Memory Access Bus Arbiter

This block hands the shared system bus to an external device that wants to move data on its own. Each candidate device drives its own request line and acknowledge line. The arbiter synchronizes both vectors into its clock domain. When a request appears, it raises a hold output. The hold stops the bus master controller from opening any new processor cycle. The arbiter then waits for any cycle already in flight to release its framing strobe, and only then issues a grant.

The grant enters a serial priority chain. The chain is the same kind used for interrupt acknowledge: the grant passes from the top-priority position downward, and the first requesting position keeps it. The winner is frozen for the whole grant, so a late request cannot steal it. When the winning device acknowledges, the grant is removed. The hold stays asserted until every acknowledge is released. After that, any request still pending is arbitrated again.

An initialization input clears all arbiter state at the next clock edge, in any phase.

Top module: `dma_bus_arbiter`

## Requirements
- R1: After reset, `bus_grant_o`, all bits of `dev_grant_o` and `bus_hold_o` are 0.
- R2: A request driven on any `dev_req_i` bit raises `bus_hold_o` exactly SYNC_STAGES+1 clock edges later. `bus_hold_o` is high whenever `bus_grant_o` is high.
- R3: `bus_grant_o` never rises in the cycle after an edge at which `cpu_cyc_busy_i` was high. While a request waits, the grant rises at the first edge that samples `cpu_cyc_busy_i` low.
- R4: With the bus idle, `bus_grant_o` rises exactly SYNC_STAGES+2 edges after a request is driven.
- R5: Bit 0 of the request vector has the highest priority. Only the lowest-index position that is requesting when the grant is issued sees its `dev_grant_o` bit set. At most one bit is ever set, and only while `bus_grant_o` is high.
- R6: A new request from a higher-priority position during an outstanding grant does not move the grant.
- R7: Any acknowledge bit removes `bus_grant_o` and `dev_grant_o` SYNC_STAGES+1 edges after it is driven, while `bus_hold_o` stays high.
- R8: `bus_hold_o` falls exactly SYNC_STAGES+1 edges after the last acknowledge bit is released.
- R9: If the granted position withdraws its request without acknowledging, the grant and the hold fall SYNC_STAGES+1 edges later.
- R10: `init_i` high clears `bus_grant_o`, `dev_grant_o` and `bus_hold_o` at the next edge from any phase. It keeps them low while held, even with requests present.
- R11: An acknowledge with no request pending is ignored: `bus_hold_o` and `bus_grant_o` stay low.
- R12: A request still pending when the bus is released is granted again, to the highest-priority remaining position, two edges after the hold falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_i | input | 1 | Synchronous initialization, clears all state |
| dev_req_i | input | N_DEV | Per-position bus requests, bit 0 highest priority |
| dev_ack_i | input | N_DEV | Per-position bus ownership acknowledges |
| cpu_cyc_busy_i | input | 1 | Framing strobe of the processor bus cycle in progress |
| bus_hold_o | output | 1 | Stops the bus master controller from starting cycles |
| bus_grant_o | output | 1 | Grant entering the head of the priority chain |
| dev_grant_o | output | N_DEV | Grant as delivered to each chain position |

## Verification
The hardest situation to reach is a grant that competes with a processor cycle. This happens when a request is sampled while the framing strobe is high, and it must hold the grant back for an arbitrary number of cycles. The bench raises the busy strobe before the request, keeps it high well past the synchronizer window, and checks every cycle that the grant stays low. It then drops the strobe and expects the grant exactly one edge later. A second hard case is a higher-priority request landing mid-grant. The bench reaches it by granting a low-priority position first and then raising bit 0 during the grant.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

    typedef enum logic [1:0] {
        ARB_IDLE  = 2'd0,
        ARB_WAIT  = 2'd1,
        ARB_GRANT = 2'd2,
        ARB_OWNED = 2'd3
    } arb_state_e;

endpackage

// File: rtl/dma_sync_vec.sv
module dma_sync_vec #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] pipe_d;
    logic [STAGES-1:0][WIDTH-1:0] pipe_q;

    // One flop rank per stage; the first rank samples the raw input.
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_head
            always_comb pipe_d[g] = clear_i ? '0 : async_i;
        end else begin : g_tail
            always_comb pipe_d[g] = clear_i ? '0 : pipe_q[g-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign sync_o = pipe_q[LAST];

endmodule

// File: rtl/dma_prio_chain.sv
module dma_prio_chain #(
    parameter int N_DEV = 4
) (
    input  logic [N_DEV-1:0] req_i,
    output logic [N_DEV-1:0] pick_o
);

    // pass[i] is high when the grant reaches position i untaken.
    logic [N_DEV:0] pass;

    assign pass[0] = 1'b1;

    for (genvar i = 0; i < N_DEV; i++) begin : g_slot
        assign pick_o[i]  = pass[i] & req_i[i];
        assign pass[i+1]  = pass[i] & ~req_i[i];
    end

endmodule

// File: rtl/dma_arb_fsm.sv
module dma_arb_fsm
    import dma_arb_pkg::*;
#(
    parameter int N_DEV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_i,
    input  logic [N_DEV-1:0] req_sync_i,
    input  logic [N_DEV-1:0] ack_sync_i,
    input  logic [N_DEV-1:0] pick_i,
    input  logic             cyc_busy_i,
    output logic             hold_o,
    output logic             grant_o,
    output logic [N_DEV-1:0] winner_o
);

    typedef struct packed {
        arb_state_e       state;
        logic [N_DEV-1:0] winner;
    } fsm_regs_t;

    fsm_regs_t regs_d;
    fsm_regs_t regs_q;

    logic req_any;
    logic ack_any;
    logic winner_req;

    always_comb begin
        req_any    = |req_sync_i;
        ack_any    = |ack_sync_i;
        winner_req = |(req_sync_i & regs_q.winner);
        regs_d     = regs_q;

        unique case (regs_q.state)
            ARB_IDLE: begin
                regs_d.winner = '0;
                if (req_any) regs_d.state = ARB_WAIT;
            end
            ARB_WAIT: begin
                if (!req_any) begin
                    regs_d.state = ARB_IDLE;
                end else if (!cyc_busy_i) begin
                    regs_d.state  = ARB_GRANT;
                    regs_d.winner = pick_i;
                end
            end
            ARB_GRANT: begin
                if (ack_any) begin
                    regs_d.state = ARB_OWNED;
                end else if (!winner_req) begin
                    regs_d.state  = ARB_IDLE;
                    regs_d.winner = '0;
                end
            end
            ARB_OWNED: begin
                if (!ack_any) begin
                    regs_d.state  = ARB_IDLE;
                    regs_d.winner = '0;
                end
            end
            default: regs_d = '0;
        endcase

        if (init_i) regs_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign hold_o   = (regs_q.state != ARB_IDLE);
    assign grant_o  = (regs_q.state == ARB_GRANT);
    assign winner_o = regs_q.winner;

endmodule

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter #(
    parameter int N_DEV       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_i,
    input  logic [N_DEV-1:0] dev_req_i,
    input  logic [N_DEV-1:0] dev_ack_i,
    input  logic             cpu_cyc_busy_i,
    output logic             bus_hold_o,
    output logic             bus_grant_o,
    output logic [N_DEV-1:0] dev_grant_o
);

    logic [N_DEV-1:0] req_sync;
    logic [N_DEV-1:0] ack_sync;
    logic [N_DEV-1:0] pick;
    logic [N_DEV-1:0] winner;
    logic             grant;

    dma_sync_vec #(.WIDTH(N_DEV), .STAGES(SYNC_STAGES)) u_req_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (init_i),
        .async_i (dev_req_i),
        .sync_o  (req_sync)
    );

    dma_sync_vec #(.WIDTH(N_DEV), .STAGES(SYNC_STAGES)) u_ack_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (init_i),
        .async_i (dev_ack_i),
        .sync_o  (ack_sync)
    );

    dma_prio_chain #(.N_DEV(N_DEV)) u_chain (
        .req_i  (req_sync),
        .pick_o (pick)
    );

    dma_arb_fsm #(.N_DEV(N_DEV)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .init_i     (init_i),
        .req_sync_i (req_sync),
        .ack_sync_i (ack_sync),
        .pick_i     (pick),
        .cyc_busy_i (cpu_cyc_busy_i),
        .hold_o     (bus_hold_o),
        .grant_o    (grant),
        .winner_o   (winner)
    );

    assign bus_grant_o = grant;
    assign dev_grant_o = {N_DEV{grant}} & winner;

endmodule

// File: rtl/dma_bus_arbiter_chk.sv
module dma_bus_arbiter_chk #(
    parameter int N_DEV = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             init_i,
    input logic             cpu_cyc_busy_i,
    input logic             bus_hold_o,
    input logic             bus_grant_o,
    input logic [N_DEV-1:0] dev_grant_o
);

    assert_grant_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dev_grant_o));

    assert_dev_grant_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|dev_grant_o) |-> bus_grant_o);

    assert_grant_after_idle_bus_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_grant_o) |-> !$past(cpu_cyc_busy_i));

    assert_hold_covers_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_grant_o |-> bus_hold_o);

    assert_hold_before_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_grant_o) |-> $past(bus_hold_o));

    assert_winner_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n || init_i)
        (bus_grant_o && $past(bus_grant_o)) |-> $stable(dev_grant_o));

    assert_init_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        init_i |=> (!bus_hold_o && !bus_grant_o));

endmodule

bind dma_bus_arbiter dma_bus_arbiter_chk #(.N_DEV(N_DEV)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .init_i         (init_i),
    .cpu_cyc_busy_i (cpu_cyc_busy_i),
    .bus_hold_o     (bus_hold_o),
    .bus_grant_o    (bus_grant_o),
    .dev_grant_o    (dev_grant_o)
);

// File: tb/dma_bus_arbiter_test.sv
module dma_bus_arbiter_test;

    localparam int CLK_PERIOD = 10;
    localparam int N_DEV      = 4;
    localparam int SYNC       = 2;
    localparam int WATCHDOG   = 20000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             init_i = 1'b0;
    logic [N_DEV-1:0] dev_req_i = '0;
    logic [N_DEV-1:0] dev_ack_i = '0;
    logic             cpu_cyc_busy_i = 1'b0;
    logic             bus_hold_o;
    logic             bus_grant_o;
    logic [N_DEV-1:0] dev_grant_o;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_bus_arbiter #(.N_DEV(N_DEV), .SYNC_STAGES(SYNC)) uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .init_i         (init_i),
        .dev_req_i      (dev_req_i),
        .dev_ack_i      (dev_ack_i),
        .cpu_cyc_busy_i (cpu_cyc_busy_i),
        .bus_hold_o     (bus_hold_o),
        .bus_grant_o    (bus_grant_o),
        .dev_grant_o    (dev_grant_o)
    );

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < %0d", cycles, WATCHDOG);
            report();
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_out(input string tag, input bit hold, input bit grant, input int devg);
        check(bus_hold_o == hold,  {tag, " hold"},  int'(bus_hold_o),  int'(hold));
        check(bus_grant_o == grant, {tag, " grant"}, int'(bus_grant_o), int'(grant));
        check(int'(dev_grant_o) == devg, {tag, " dev_grant"}, int'(dev_grant_o), devg);
    endtask

    task automatic edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Owner acknowledges, drops its request, then releases; bus ends idle.
    task automatic finish_owned(input int idx);
        @(negedge clk);
        dev_ack_i[idx] = 1'b1;
        dev_req_i[idx] = 1'b0;
        edges(SYNC + 3);
        dev_ack_i[idx] = 1'b0;
        edges(SYNC + 3);
    endtask

    task automatic t_reset();
        chk_out("R1 reset", 1'b0, 1'b0, 0);
    endtask

    task automatic t_basic();
        @(negedge clk);
        dev_req_i[2] = 1'b1;
        edges(SYNC);
        chk_out("R2 before hold", 1'b0, 1'b0, 0);
        edges(1);
        chk_out("R2 hold raised", 1'b1, 1'b0, 0);
        edges(1);
        chk_out("R4 grant issued", 1'b1, 1'b1, 4);
        dev_ack_i[2] = 1'b1;
        dev_req_i[2] = 1'b0;
        edges(SYNC);
        chk_out("R7 grant before ack seen", 1'b1, 1'b1, 4);
        edges(1);
        chk_out("R7 ack removes grant", 1'b1, 1'b0, 0);
        edges(5);
        chk_out("R8 hold kept while ack", 1'b1, 1'b0, 0);
        dev_ack_i[2] = 1'b0;
        edges(SYNC);
        chk_out("R8 hold before release seen", 1'b1, 1'b0, 0);
        edges(1);
        chk_out("R8 hold released", 1'b0, 1'b0, 0);
    endtask

    task automatic t_busy_wait();
        @(negedge clk);
        cpu_cyc_busy_i = 1'b1;
        dev_req_i[0] = 1'b1;
        edges(SYNC + 1);
        chk_out("R3 hold during cycle", 1'b1, 1'b0, 0);
        for (int i = 0; i < 6; i++) begin
            edges(1);
            chk_out("R3 no grant while busy", 1'b1, 1'b0, 0);
        end
        cpu_cyc_busy_i = 1'b0;
        edges(1);
        chk_out("R3 grant after strobe release", 1'b1, 1'b1, 1);
        finish_owned(0);
    endtask

    task automatic t_priority();
        @(negedge clk);
        dev_req_i = 4'b1010;
        edges(SYNC + 2);
        chk_out("R5 lowest index wins", 1'b1, 1'b1, 2);
        dev_req_i[0] = 1'b1;
        edges(SYNC + 3);
        chk_out("R6 late higher request ignored", 1'b1, 1'b1, 2);
        dev_ack_i[1] = 1'b1;
        dev_req_i[1] = 1'b0;
        edges(SYNC + 3);
        chk_out("R7 owned by position 1", 1'b1, 1'b0, 0);
        dev_ack_i[1] = 1'b0;
        edges(SYNC + 1);
        chk_out("R12 released", 1'b0, 1'b0, 0);
        edges(2);
        chk_out("R12 regrant to position 0", 1'b1, 1'b1, 1);
        finish_owned(0);
        edges(2);
        chk_out("R12 regrant to position 3", 1'b1, 1'b1, 8);
        finish_owned(3);
    endtask

    task automatic t_withdraw();
        @(negedge clk);
        dev_req_i[3] = 1'b1;
        edges(SYNC + 2);
        chk_out("R9 granted", 1'b1, 1'b1, 8);
        dev_req_i[3] = 1'b0;
        edges(SYNC);
        chk_out("R9 grant before withdraw seen", 1'b1, 1'b1, 8);
        edges(1);
        chk_out("R9 withdraw clears", 1'b0, 1'b0, 0);
    endtask

    task automatic t_spurious_ack();
        @(negedge clk);
        dev_ack_i[1] = 1'b1;
        edges(SYNC + 4);
        chk_out("R11 stray ack ignored", 1'b0, 1'b0, 0);
        dev_ack_i[1] = 1'b0;
        edges(SYNC + 2);
        chk_out("R11 idle after stray ack", 1'b0, 1'b0, 0);
    endtask

    task automatic t_init();
        @(negedge clk);
        dev_req_i[1] = 1'b1;
        edges(SYNC + 2);
        chk_out("R10 granted before init", 1'b1, 1'b1, 2);
        init_i = 1'b1;
        edges(1);
        chk_out("R10 init clears grant", 1'b0, 1'b0, 0);
        init_i = 1'b0;
        edges(SYNC + 2);
        chk_out("R10 request rearbitrated", 1'b1, 1'b1, 2);
        dev_ack_i[1] = 1'b1;
        dev_req_i[1] = 1'b0;
        edges(SYNC + 3);
        chk_out("R10 owned before init", 1'b1, 1'b0, 0);
        dev_req_i[0] = 1'b1;
        init_i = 1'b1;
        edges(1);
        chk_out("R10 init clears hold", 1'b0, 1'b0, 0);
        edges(SYNC + 3);
        chk_out("R10 held init keeps idle", 1'b0, 1'b0, 0);
        dev_req_i = '0;
        dev_ack_i = '0;
        edges(1);
        init_i = 1'b0;
        edges(SYNC + 3);
        chk_out("R10 idle after init", 1'b0, 1'b0, 0);
    endtask

    initial begin
        edges(3);
        rst_n = 1'b1;
        edges(2);
        t_reset();
        t_basic();
        t_busy_wait();
        t_priority();
        t_withdraw();
        t_spurious_ack();
        t_init();
        edges(2);
        report();
    end

endmodule